// File: doc/BRIEF.md
# Store Buffer with Load Bypassing and Forwarding

This block sits between a load/store pipeline and a single-port data memory and decides the order in which memory sees the requests. Stores are not written at once. They are parked in a small in-order queue and written back one at a time, whenever the memory port is free and the memory grants it. Loads are allowed to jump ahead of those parked stores. A load whose word address matches no parked store reads memory in the cycle it is presented. A load whose address matches one or more parked stores never touches memory. It takes its value from the youngest matching entry instead.

The pipeline sees one request port with a valid/ready handshake. Each request carries a kind (load or store), a word address and write data. Every accepted load gets exactly one response, in the cycle after it was accepted. The memory side is a request/grant port. A read granted in one cycle returns its data in the next cycle, and a write is performed in the granted cycle. From the pipeline's point of view, every load returns the value that a strictly sequential machine would have returned.

Top module: `ldst_order_unit`

## Requirements
- R1: After reset the buffer is empty, `rsp_valid` and `mem_req` are low, and a store request sees `req_ready` high.
- R2: An accepted store is never written to memory in its own acceptance cycle. Parked stores reach memory later, one per granted write, in exactly the order they were accepted, each with its own address and data.
- R3: The buffer holds `SB_DEPTH` (default 4) stores. While it holds that many, a store request sees `req_ready` low.
- R4: A load whose address equals no parked store, presented while the buffer is not full, drives a read (`mem_req`=1, `mem_we`=0, `mem_addr`=`req_addr`) in that same cycle, ahead of all parked stores. It is accepted exactly when `mem_gnt` is high.
- R5: A load whose address equals a parked store is accepted at once, whatever `mem_gnt` is and even when the buffer is full. It issues no memory read, and its response carries the data of the youngest matching parked store.
- R6: `rsp_valid` is high in exactly the cycles that follow a cycle in which a load was accepted. For a load served by memory, `rsp_data` equals `mem_rdata` in that cycle.
- R7: While the buffer is full, a load matching no parked store is held with `req_ready` low, and the port is given to writing back the oldest store.
- R8: Whenever the buffer is not empty and no bypassing load takes the port, the block requests a write of the oldest parked store. It removes exactly one entry per granted write.
- R9: Every load returns the value implied by applying all earlier accepted stores in program order to memory. No load ever sees stale memory, and no store lands before an older load has read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The presented request is taken this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | DATA_W | Load response data |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_gnt | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | DATA_W | Read data, one cycle after a granted read |

## Verification
Directed sequences come first. They hold the grant low to stack four stores, two of them to the same address. This shows youngest-entry forwarding apart from oldest-entry forwarding, and a full-buffer stall apart from a matching load that must still pass. A load to a fresh address with the buffer full, followed by the same load one entry later, shows the write-back-first rule apart from the load-first rule. The random phase confines addresses to eight words and withholds the grant about a quarter of the time. This mix of hits, misses, back-to-back stores and blocked drains catches any mismatch between the order of memory writes and the sequential model, and any load that returns stale data.

// File: rtl/sob_pkg.sv
package sob_pkg;

  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_LOAD  = 2'd1,
    PORT_DRAIN = 2'd2
  } port_sel_e;

  // successor of a ring position
  function automatic int ring_next(int p, int depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // age of a ring slot counted from the oldest entry (0 = oldest)
  function automatic int entry_age(int idx, int head, int depth);
    return (idx >= head) ? idx - head : idx + depth - head;
  endfunction

  // bench-visible rule: load needs the port when it hits nothing
  function automatic logic wants_port(logic is_load, logic hit);
    return is_load && !hit;
  endfunction

endpackage

// File: rtl/sob_queue.sv
module sob_queue
  import sob_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DEPTH-1:0][AW-1:0]   ent_addr,
  output logic [DEPTH-1:0][DW-1:0]   ent_data,
  output logic [DEPTH-1:0]           ent_vld,
  output logic [PW-1:0]              head_ptr,
  output logic [CW-1:0]              count,
  output logic                       full,
  output logic                       empty,
  output logic [AW-1:0]              head_addr,
  output logic [DW-1:0]              head_data
);

  logic [PW-1:0] tail_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      count    <= '0;
      ent_vld  <= '0;
    end else begin
      if (push) begin
        ent_vld[tail_ptr] <= 1'b1;
        tail_ptr          <= PW'(ring_next(int'(tail_ptr), DEPTH));
      end
      if (pop) begin
        ent_vld[head_ptr] <= 1'b0;
        head_ptr          <= PW'(ring_next(int'(head_ptr), DEPTH));
      end
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // payload storage needs no reset: ent_vld qualifies it
  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[tail_ptr] <= push_addr;
      ent_data[tail_ptr] <= push_data;
    end
  end

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign head_addr = ent_addr[head_ptr];
  assign head_data = ent_data[head_ptr];

endmodule

// File: rtl/sob_fwd_match.sv
module sob_fwd_match
  import sob_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic [DEPTH-1:0]         ent_vld,
  input  logic [PW-1:0]            head_ptr,
  input  logic [AW-1:0]            look_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);

  logic [DEPTH-1:0] eq;
  int               best_age;
  int               cur_age;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = ent_vld[g] && (ent_addr[g] == look_addr);
  end

  // youngest matching entry wins
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    best_age = 0;
    cur_age  = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (eq[i]) begin
        cur_age = entry_age(i, int'(head_ptr), DEPTH);
        if (!hit || cur_age > best_age) begin
          hit      = 1'b1;
          best_age = cur_age;
          hit_data = ent_data[i];
        end
      end
    end
  end

endmodule

// File: rtl/sob_port_arb.sv
module sob_port_arb
  import sob_pkg::*;
(
  input  logic      req_valid,
  input  logic      req_is_store,
  input  logic      fwd_hit,
  input  logic      sb_full,
  input  logic      sb_empty,
  input  logic      mem_gnt,
  output port_sel_e sel,
  output logic      req_ready,
  output logic      load_byp,
  output logic      load_fwd,
  output logic      store_push,
  output logic      drain_fire,
  output logic      mem_req,
  output logic      mem_we
);

  logic is_load;
  logic byp_cand;

  assign is_load  = req_valid && !req_is_store;
  assign byp_cand = wants_port(is_load, fwd_hit);

  // bypassing load first, unless the buffer is full
  always_comb begin
    if (byp_cand && !sb_full) begin
      sel = PORT_LOAD;
    end else if (!sb_empty) begin
      sel = PORT_DRAIN;
    end else begin
      sel = PORT_IDLE;
    end
  end

  always_comb begin
    if (req_is_store) begin
      req_ready = !sb_full;
    end else if (fwd_hit) begin
      req_ready = 1'b1;
    end else begin
      req_ready = !sb_full && mem_gnt;
    end
  end

  assign mem_req    = (sel != PORT_IDLE);
  assign mem_we     = (sel == PORT_DRAIN);
  assign drain_fire = (sel == PORT_DRAIN) && mem_gnt;
  assign load_byp   = (sel == PORT_LOAD) && mem_gnt;
  assign load_fwd   = is_load && fwd_hit;
  assign store_push = req_valid && req_is_store && !sb_full;

endmodule

// File: rtl/ldst_order_unit.sv
module ldst_order_unit
  import sob_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int SB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int PTR_W = (SB_DEPTH > 1) ? $clog2(SB_DEPTH) : 1;
  localparam int CNT_W = $clog2(SB_DEPTH + 1);

  // named internal events
  logic                             store_push;
  logic                             drain_fire;
  logic                             load_byp;
  logic                             load_fwd;
  logic                             fwd_hit;
  logic [DATA_W-1:0]                fwd_data;
  logic                             sb_full;
  logic                             sb_empty;
  logic [CNT_W-1:0]                 sb_count;
  logic [PTR_W-1:0]                 sb_head;
  logic [SB_DEPTH-1:0][ADDR_W-1:0]  sb_addr;
  logic [SB_DEPTH-1:0][DATA_W-1:0]  sb_data;
  logic [SB_DEPTH-1:0]              sb_vld;
  logic [ADDR_W-1:0]                sb_head_addr;
  logic [DATA_W-1:0]                sb_head_data;
  port_sel_e                        sel;

  logic                             rsp_valid_q;
  logic                             rsp_from_buf_q;
  logic [DATA_W-1:0]                fwd_data_q;

  sob_queue #(
    .AW   (ADDR_W),
    .DW   (DATA_W),
    .DEPTH(SB_DEPTH)
  ) queue_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (store_push),
    .push_addr(req_addr),
    .push_data(req_wdata),
    .pop      (drain_fire),
    .ent_addr (sb_addr),
    .ent_data (sb_data),
    .ent_vld  (sb_vld),
    .head_ptr (sb_head),
    .count    (sb_count),
    .full     (sb_full),
    .empty    (sb_empty),
    .head_addr(sb_head_addr),
    .head_data(sb_head_data)
  );

  sob_fwd_match #(
    .AW   (ADDR_W),
    .DW   (DATA_W),
    .DEPTH(SB_DEPTH)
  ) match_i (
    .ent_addr (sb_addr),
    .ent_data (sb_data),
    .ent_vld  (sb_vld),
    .head_ptr (sb_head),
    .look_addr(req_addr),
    .hit      (fwd_hit),
    .hit_data (fwd_data)
  );

  sob_port_arb arb_i (
    .req_valid   (req_valid),
    .req_is_store(req_is_store),
    .fwd_hit     (fwd_hit),
    .sb_full     (sb_full),
    .sb_empty    (sb_empty),
    .mem_gnt     (mem_gnt),
    .sel         (sel),
    .req_ready   (req_ready),
    .load_byp    (load_byp),
    .load_fwd    (load_fwd),
    .store_push  (store_push),
    .drain_fire  (drain_fire),
    .mem_req     (mem_req),
    .mem_we      (mem_we)
  );

  assign mem_addr  = (sel == PORT_LOAD) ? req_addr : sb_head_addr;
  assign mem_wdata = sb_head_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q    <= 1'b0;
      rsp_from_buf_q <= 1'b0;
      fwd_data_q     <= '0;
    end else begin
      rsp_valid_q    <= load_fwd || load_byp;
      rsp_from_buf_q <= load_fwd;
      if (load_fwd) begin
        fwd_data_q <= fwd_data;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_from_buf_q ? fwd_data_q : mem_rdata;

endmodule

// File: rtl/ldst_order_unit_chk.sv
module ldst_order_unit_chk #(
  parameter int SB_DEPTH = 4,
  localparam int CNT_W   = $clog2(SB_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_is_store,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_gnt,
  input logic             rsp_valid,
  input logic [CNT_W-1:0] sb_count,
  input logic             sb_full,
  input logic             load_fwd,
  input logic             load_byp,
  input logic             drain_fire,
  input logic             store_push
);

  // R3
  sb_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_count <= CNT_W'(SB_DEPTH));

  // R3
  full_store_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_full && req_valid && req_is_store) |-> !req_ready);

  // R6
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_is_store) |=> rsp_valid);

  // R6
  rsp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_is_store) |=> !rsp_valid);

  // R5
  fwd_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fwd |-> !(mem_req && !mem_we));

  // R7
  full_drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_full && mem_gnt) |-> (mem_req && mem_we && drain_fire));

  // R4
  byp_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_byp |-> (!sb_full && mem_req && !mem_we));

  // R8
  write_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (sb_count != '0));

  // R2
  count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_push && !drain_fire) |=> (sb_count == $past(sb_count) + CNT_W'(1)));

endmodule

bind ldst_order_unit ldst_order_unit_chk #(.SB_DEPTH(SB_DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_is_store(req_is_store),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_gnt     (mem_gnt),
  .rsp_valid   (rsp_valid),
  .sb_count    (sb_count),
  .sb_full     (sb_full),
  .load_fwd    (load_fwd),
  .load_byp    (load_byp),
  .drain_fire  (drain_fire),
  .store_push  (store_push)
);

// File: tb/ldst_order_unit_tb_top.sv
module ldst_order_unit_tb_top;

  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_is_store;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_gnt;
  logic [DW-1:0] mem_rdata;

  always #2 clk = ~clk;  // 250 MHz

  ldst_order_unit #(.ADDR_W(AW), .DATA_W(DW), .SB_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_store(req_is_store),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] init_word(int i);
    return 32'hA000_0000 + 32'(i);
  endfunction

  // memory model: write in granted cycle, read data one cycle later
  logic [DW-1:0] bmem [16];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) bmem[i] <= init_word(i);
      mem_rdata <= '0;
    end else if (mem_req && mem_gnt) begin
      if (mem_we) bmem[mem_addr[3:0]] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr[3:0]];
    end
  end

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [DW-1:0] ref_mem [16];
  logic [AW-1:0] q_addr [$];
  logic [DW-1:0] q_data [$];
  bit            pend = 1'b0;
  logic [DW-1:0] pend_exp;

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit in_queue(logic [AW-1:0] a);
    foreach (q_addr[i]) if (q_addr[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(bit v, bit st, logic [AW-1:0] a, logic [DW-1:0] d, bit g);
    bit hit;
    int size;
    bit byp;
    @(negedge clk);
    if (pend) begin
      chk(rsp_valid == 1'b1, "R6 rsp_valid", 32'(rsp_valid), 32'd1);
      chk(rsp_data == pend_exp, "R9 load data", rsp_data, pend_exp);
    end else begin
      chk(rsp_valid == 1'b0, "R6 spurious rsp", 32'(rsp_valid), 32'd0);
    end
    pend = 1'b0;
    req_valid = v; req_is_store = st; req_addr = a; req_wdata = d; mem_gnt = g;
    #1;
    hit  = in_queue(a);
    size = q_addr.size();
    byp  = v && !st && !hit && (size < DEPTH);
    if (size > 0 && !byp)
      chk(mem_req && mem_we, "R8 drain request", 32'(mem_req && mem_we), 32'd1);
    if (mem_req && mem_gnt && mem_we) begin
      if (size == 0) begin
        chk(1'b0, "R2 write with nothing parked", mem_wdata, '1);
      end else begin
        chk(mem_addr == q_addr[0] && mem_wdata == q_data[0], "R2 write order",
            mem_wdata, q_data[0]);
        void'(q_addr.pop_front());
        void'(q_data.pop_front());
      end
    end
    if (v && !st && !hit) begin
      if (size < DEPTH) begin
        chk(mem_req && !mem_we && mem_addr == a, "R4 bypass read", 32'(mem_addr), 32'(a));
        chk(req_ready == g, "R4 ready follows grant", 32'(req_ready), 32'(g));
      end else begin
        chk(req_ready == 1'b0, "R7 full load stall", 32'(req_ready), 32'd0);
      end
    end
    if (v && !st && hit)
      chk(req_ready && !(mem_req && !mem_we), "R5 forward no read",
          32'(req_ready), 32'd1);
    if (v && st)
      chk(req_ready == (size < DEPTH), "R3 store ready", 32'(req_ready), 32'(size < DEPTH));
    if (v && req_ready) begin
      if (st) begin
        ref_mem[a[3:0]] = d;
        q_addr.push_back(a);
        q_data.push_back(d);
      end else begin
        pend     = 1'b1;
        pend_exp = ref_mem[a[3:0]];
      end
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(20240);
    rst_n = 1'b0; req_valid = 1'b0; req_is_store = 1'b1;
    req_addr = '0; req_wdata = '0; mem_gnt = 1'b1;
    for (int i = 0; i < 16; i++) ref_mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
    chk(req_ready == 1'b1, "R1 store ready", 32'(req_ready), 32'd1);

    // R2: store into empty buffer is not written in its own cycle
    step(1, 1, 16'h1, 32'h0000_0011, 1);
    step(0, 0, 16'h0, 32'h0, 1);
    // fill with grant withheld, two entries to address 2 (R3, R5)
    step(1, 1, 16'h1, 32'h1111_0001, 0);
    step(1, 1, 16'h2, 32'h2222_0002, 0);
    step(1, 1, 16'h3, 32'h3333_0003, 0);
    step(1, 1, 16'h2, 32'h4444_0004, 0);
    step(1, 1, 16'h5, 32'h5555_0005, 0);   // R3 stall
    step(1, 0, 16'h2, 32'h0, 0);           // R5 youngest forward
    step(1, 0, 16'h7, 32'h0, 1);           // R7 full: drain first
    step(1, 0, 16'h7, 32'h0, 1);           // R4 bypass ahead of 3 stores
    repeat (4) step(0, 0, 16'h0, 32'h0, 1); // R8 drains
    step(1, 0, 16'h2, 32'h0, 1);           // R9 read drained value
    step(0, 0, 16'h0, 32'h0, 1);

    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 5) != 0, $urandom % 2, 16'($urandom % 8), $urandom,
           ($urandom % 4) != 0);
    end
    repeat (8) step(0, 0, 16'h0, 32'h0, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule